// File: doc/BRIEF.md
# Programmable Periodic Event Divider

This block turns a 32.768 kHz tick enable into a periodic event. It has a free-running 16-bit tick counter that advances once for every clock cycle in which the tick enable is high. A 4-bit rate code and an enable bit choose a period that is a power of two in ticks. The block gives a one-cycle event pulse each time the counter reaches a whole multiple of that period.

Events follow the grid of period multiples on the free-running counter. They are not counted from the moment the block is programmed. When the rate code changes, the block computes a new target right away: the next multiple of the new period above the current count. Clearing the enable, or selecting rate code zero, stops the output and discards the pending target.

The controller is a three-state machine:
- `ST_OFF` is idle: the output is disabled and no target is held.
- `ST_WAIT` is armed: a target is held.
- `ST_FIRE` is the cycle in which the pulse is driven.

The named transitions are:
- **arm**: `ST_OFF` to `ST_WAIT`, taken when enabled with a nonzero code.
- **hit**: any enabled state to `ST_FIRE`, taken when a tick carries the counter onto the target.
- **rearm**: `ST_FIRE` to `ST_WAIT`.
- **cancel**: any state to `ST_OFF`, taken when disabled.
- **retarget**: stays in `ST_WAIT` or `ST_FIRE`, but reloads the target from the current count because the code changed.

Top module: `pid_periodic_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the event output is low and the tick counter is zero. The first event at period P therefore follows the P-th tick after reset.
- R2: When the enable is low, or the rate code is 0, no event is produced. Any target held before that is discarded.
- R3: For a rate code n from 3 to 15, the period is 2^(n-1) ticks.
- R4: Rate code 1 gives a period of 128 ticks, and rate code 2 gives a period of 256 ticks.
- R5: Events occur only where the free-running counter reaches a multiple of the period. After a rate change, the next event is at the first multiple of the new period above the current count.
- R6: The event is high for exactly one clock cycle. It only follows a cycle in which the tick enable was high.
- R7: The tick counter is 16 bits wide and wraps from 65535 to 0. Events keep their alignment across the wrap.
- R8: Suppose a clock edge sees the tick enable high, the block enabled, and the count plus one equal to a multiple of the period. The event output is then high for the clock cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz tick enable, one cycle wide per tick |
| rate_sel | input | 4 | Rate code: 0 is off, 1 and 2 are slow aliases, 3 to 15 give a period of 2^(n-1) ticks |
| periodic_en | input | 1 | Enables the periodic event |
| evt_o | output | 1 | One-cycle periodic event pulse |

## Verification
Two things can land in the same cycle:
- a retarget caused by a rate-code change;
- a tick that carries the counter onto a period multiple.

The random phase changes the rate code and the enable on arbitrary cycles, with the tick enable at 50% density. This makes changes fall on crossing cycles many times. The bench model then decides the outcome from the newly applied code and the count before the tick. A pulse is expected only if the count plus one is a multiple of the new period. A disable in the same cycle must win over the crossing.

// File: rtl/pid_pkg.sv
package pid_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIRE = 2'd2
    } pid_state_e;

    // Codes 1 and 2 behave like the slower codes 8 and 9.
    function automatic logic [3:0] pid_eff_code(input logic [3:0] code);
        logic [3:0] r;
        if (code == 4'd1 || code == 4'd2) r = code + 4'd7;
        else                              r = code;
        return r;
    endfunction

endpackage

// File: rtl/pid_tick_counter.sv
module pid_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_o <= '0;
        else if (tick_en) cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/pid_rate_decode.sv
module pid_rate_decode #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] rate_sel,
    output logic             active_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] mask_o
);
    import pid_pkg::*;

    localparam int NCODES = 1 << SEL_W;

    logic [3:0]       eff;
    logic [CNT_W-1:0] per_tab [NCODES];

    // Build the period for every code, so that the lookup is a plain mux.
    generate
        for (genvar c = 0; c < NCODES; c++) begin : g_code
            localparam logic [3:0] EFF = pid_eff_code(4'(c));
            if (c == 0) begin : g_zero
                assign per_tab[c] = '0;
            end else begin : g_pow
                assign per_tab[c] = CNT_W'(1) << (EFF - 1);
            end
        end
    endgenerate

    assign eff      = pid_eff_code(4'(rate_sel));
    assign active_o = (rate_sel != '0);
    assign period_o = per_tab[rate_sel];
    assign mask_o   = active_o ? (period_o - 1'b1) : '0;

endmodule

// File: rtl/pid_periodic_divider.sv
module pid_periodic_divider #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             periodic_en,
    output logic             evt_o
);
    import pid_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] mask;
    logic             active;
    logic [CNT_W-1:0] tgt_q, tgt_eff, tgt_d;
    logic [SEL_W-1:0] rate_q;
    logic             en_now, fresh, hit;
    pid_state_e       st_q, st_d;

    pid_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_o   (cnt_q)
    );

    pid_rate_decode #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_dec (
        .rate_sel (rate_sel),
        .active_o (active),
        .period_o (period),
        .mask_o   (mask)
    );

    assign en_now  = periodic_en && active;
    // A new target is needed when the block is being armed or when the rate code has changed.
    assign fresh   = (st_q == ST_OFF) || (rate_sel != rate_q);
    assign tgt_eff = fresh ? ((cnt_q & ~mask) + period) : tgt_q;
    assign cnt_inc = cnt_q + 1'b1;
    assign hit     = en_now && tick_en && (cnt_inc == tgt_eff);
    assign tgt_d   = hit ? (tgt_eff + period) : tgt_eff;

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (!en_now)  st_d = ST_OFF;    // stay idle
                else if (hit) st_d = ST_FIRE;   // hit
                else          st_d = ST_WAIT;   // arm
            end
            ST_WAIT: begin
                if (!en_now)  st_d = ST_OFF;    // cancel
                else if (hit) st_d = ST_FIRE;   // hit
                else          st_d = ST_WAIT;   // wait, or retarget
            end
            ST_FIRE: begin
                if (!en_now)  st_d = ST_OFF;    // cancel
                else if (hit) st_d = ST_FIRE;   // hit
                else          st_d = ST_WAIT;   // rearm
            end
            default: st_d = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            tgt_q  <= '0;
            rate_q <= '0;
        end else begin
            st_q   <= st_d;
            rate_q <= rate_sel;
            tgt_q  <= en_now ? tgt_d : '0;
        end
    end

    // Output decode.
    always_comb begin
        evt_o = (st_q == ST_FIRE);
    end

endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [SEL_W-1:0] rate_sel,
    input logic             periodic_en,
    input logic             evt_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] mask
);
    a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic_en || rate_sel == '0) |=> !evt_o);

    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

    a_r6_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(tick_en));

    a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ((cnt_q & $past(mask)) == '0));

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !evt_o);
endmodule

bind pid_periodic_divider pid_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .rate_sel    (rate_sel),
    .periodic_en (periodic_en),
    .evt_o       (evt_o),
    .cnt_q       (cnt_q),
    .mask        (mask)
);

// File: tb/pid_periodic_divider_tb_top.sv
module pid_periodic_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       periodic_en = 1'b0;
    logic       evt_o;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    logic [15:0] bcnt   = 16'd0;
    int unsigned ev_seen = 0;

    always #5 clk = ~clk;

    pid_periodic_divider dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .rate_sel    (rate_sel),
        .periodic_en (periodic_en),
        .evt_o       (evt_o)
    );

    function automatic int unsigned exp_period(input logic [3:0] code);
        if (code == 4'd0) return 0;
        if (code == 4'd1) return 128;          // R4
        if (code == 4'd2) return 256;          // R4
        return 32'd1 << (code - 1);            // R3
    endfunction

    // One clock: apply the inputs, let the edge pass, then compare at the next negedge.
    task automatic step(input logic t, input logic [3:0] c, input logic e, input string req);
        int unsigned p;
        logic        expv;
        logic [15:0] nxt;
        tick_en = t; rate_sel = c; periodic_en = e;
        @(posedge clk);
        @(negedge clk);
        p    = exp_period(c);
        nxt  = bcnt + 16'd1;
        expv = t && e && (p != 0) && ((32'(nxt) % p) == 0);
        n_vec++;
        if (evt_o !== expv) begin
            n_fail++;
            $display("FAIL %s: evt_o=%0b expected=%0b (count=%0d code=%0d en=%0b)",
                     req, evt_o, expv, bcnt, c, e);
        end
        if (expv) ev_seen++;
        if (t) bcnt = nxt;
    endtask

    initial begin
        #(190000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1: output quiet during reset
        repeat (4) begin
            @(negedge clk);
            n_vec++;
            if (evt_o !== 1'b0) begin
                n_fail++;
                $display("FAIL R1: evt_o=%0b expected=0 in reset", evt_o);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 4'd3, 1'b1, "R1");

        // R3, R8: smallest period, ticking every cycle
        for (int i = 0; i < 40; i++) step(1'b1, 4'd3, 1'b1, "R3_R8");
        // R3: sparse ticks
        for (int i = 0; i < 80; i++) step(i[1:0] == 2'd0, 4'd4, 1'b1, "R3");
        // R4: alias codes
        for (int i = 0; i < 300; i++) step(1'b1, 4'd1, 1'b1, "R4");
        for (int i = 0; i < 600; i++) step(1'b1, 4'd2, 1'b1, "R4");
        // R5: change the rate in the middle of a long period
        for (int i = 0; i < 77; i++) step(1'b1, 4'd9, 1'b1, "R5");
        for (int i = 0; i < 40; i++) step(1'b1, 4'd4, 1'b1, "R5");
        // R2: disabled, then code 0
        for (int i = 0; i < 100; i++) step(1'b1, 4'd5, 1'b0, "R2");
        for (int i = 0; i < 100; i++) step(1'b1, 4'd0, 1'b1, "R2");
        // R3: largest period
        for (int i = 0; i < 16500; i++) step(1'b1, 4'd15, 1'b1, "R3");
        // R7: run across the counter wrap
        while (bcnt != 16'hFFF0) step(1'b1, 4'd6, 1'b1, "R7");
        for (int i = 0; i < 200; i++) step(1'b1, 4'd6, 1'b1, "R7");
        // R5, R6: random rate changes, tick density and enables
        for (int i = 0; i < 50000; i++) begin
            logic [3:0] c;
            logic       e;
            logic       t;
            int unsigned r;
            r = $urandom % 16;
            c = (r < 10) ? 4'(3 + (r % 4)) : (r < 13 ? 4'(r - 11) : 4'(r % 9));
            e = ($urandom % 10) != 0;
            t = $urandom % 2;
            step(t, c, e, "R5_R6");
        end

        n_vec++;
        if (ev_seen == 0) begin
            n_fail++;
            $display("FAIL R6: events seen=%0d expected>0", ev_seen);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule